// File: doc/BRIEF.md
# Byte-Addressed Load Store Unit

This unit connects a processor's data path to a 32-bit-wide memory whose addresses count bytes. For each request it adds a base value and a sign-extended 16-bit displacement to form a byte address, then performs a full-word read, a full-word write or a single-byte read. Word accesses must fall on a four-byte boundary. A word access that does not is refused: no memory cycle is started and a fault flag is raised.

The order in which the four bytes of a word map onto data bits is set by a parameter. With big-endian ordering the byte at the lowest address is the most significant. With little-endian ordering it is the least significant. Stores place bytes into the memory lanes in the same order that loads read them. A byte read works at any address and returns the byte sign-extended to 32 bits.

The memory is synchronous and returns read data one clock after the request. The unit answers every accepted request with a one-cycle response pulse in the next cycle.

Top module: `lsu_core`

## Requirements
- R1: The byte address is `base_addr` plus `offset` sign-extended to 32 bits, modulo 2^32; `mem_addr` carries that address with its two low bits forced to 0, and memory lane k (bits 8k+7:8k of `mem_rdata`/`mem_wdata`) holds the byte at `mem_addr + k`.
- R2: `req_op` encodes 00 = word load, 01 = word store, 10 = byte load, 11 = idle; a request with `req_op` = 11 or `req_valid` low starts no memory cycle and produces no response.
- R3: A word load or word store whose byte address has nonzero low two bits drives neither `mem_rd_en` nor `mem_wr_en`; in the next cycle `resp_valid` and `fault` are 1 and `resp_data` is 0.
- R4: With `BIG_ENDIAN` = 1, a word load returns the byte at the lowest address in bits 31:24 and the byte at the highest address in bits 7:0 (bytes 2, 3, 10, 1 read as 33753601).
- R5: With `BIG_ENDIAN` = 0, a word load returns the byte at the lowest address in bits 7:0 and the byte at the highest address in bits 31:24 (bytes 2, 3, 10, 1 read as 17433346).
- R6: A byte load reads the byte at the exact byte address, at any alignment, and returns it sign-extended to 32 bits; it never faults.
- R7: An aligned word store asserts `mem_wr_en` for one cycle and places `store_data` into the four lanes in the byte order used by loads, so a later load of the same word returns the stored value.
- R8: Every accepted request (`req_valid` = 1, `req_op` ≠ 11) gives `resp_valid` = 1 exactly one cycle later; for a store `resp_data` is 0 and `fault` is 0.
- R9: While `rst_n` is low at a clock edge, `resp_valid`, `fault` and `resp_data` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed byte displacement |
| store_data | input | 32 | Word to write on a store |
| mem_addr | output | 32 | Word-aligned byte address to memory |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe, all four lanes |
| mem_wdata | output | 32 | Write data arranged by lane |
| mem_rdata | input | 32 | Read data by lane, one cycle after `mem_rd_en` |
| resp_valid | output | 1 | Response pulse, one cycle after the request |
| resp_data | output | 32 | Loaded value, extended to 32 bits |
| fault | output | 1 | Misaligned word access, valid with `resp_valid` |

## Verification
The bench builds two copies side by side: `dut` with `BIG_ENDIAN` = 1 and `dut_le` with `BIG_ENDIAN` = 0. Each drives its own 256-byte memory, and both see the same request stream. Running the two together puts the lane reversal of both orderings within reach, for loads and stores alike. It also shows directly that the same bytes read as 33753601 in one ordering and as 17433346 in the other. The default 32-bit address lets random bases and displacements wrap around the top of the address space, which exercises the sign extension and the modulo addition.

// File: rtl/lsu_pkg.sv
// Shared definitions for the load store unit.
// Assumes a two-bit operation field driven by the processor.
package lsu_pkg;
    typedef enum logic [1:0] {
        OP_LDW = 2'b00,
        OP_STW = 2'b01,
        OP_LDB = 2'b10,
        OP_NOP = 2'b11
    } lsu_op_e;
endpackage

// File: rtl/lsu_agen.sv
// Address generator: adds a sign-extended displacement to a base value,
// splits the result into a word-aligned line address and a lane index,
// and flags addresses that do not sit on a word boundary.
// Assumes DW/8 is a power of two.
module lsu_agen #(
    parameter int AW    = 32,
    parameter int OFF_W = 16,
    parameter int DW    = 32
) (
    input  logic [AW-1:0]     base,
    input  logic [OFF_W-1:0]  disp,
    output logic [AW-1:0]     line_addr,
    output logic [$clog2(DW/8)-1:0] lane,
    output logic              unaligned
);
    localparam int LANE_W = $clog2(DW/8);

    logic [AW-1:0] byte_addr;

    // Form the byte address with the displacement sign-extended to AW bits.
    always_comb begin
        byte_addr = base + {{(AW-OFF_W){disp[OFF_W-1]}}, disp};
        line_addr = {byte_addr[AW-1:LANE_W], {LANE_W{1'b0}}};
        lane      = byte_addr[LANE_W-1:0];
        unaligned = |byte_addr[LANE_W-1:0];
    end
endmodule

// File: rtl/lsu_store_pack.sv
// Store packer: places the bytes of a register word into memory lanes.
// Lane k receives the byte destined for line address + k; BIG puts the
// most significant byte into lane 0.
module lsu_store_pack #(
    parameter int DW  = 32,
    parameter bit BIG = 1'b1
) (
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] lanes_out
);
    localparam int NB = DW / 8;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        if (BIG) begin : g_big
            assign lanes_out[8*k +: 8] = word_in[DW-1-8*k -: 8];
        end else begin : g_little
            assign lanes_out[8*k +: 8] = word_in[8*k +: 8];
        end
    end
endmodule

// File: rtl/lsu_load_unpack.sv
// Load unpacker: turns memory lanes into a register value. A word is
// assembled in the selected byte order; a single byte is picked by
// lane index and sign-extended.
module lsu_load_unpack #(
    parameter int DW  = 32,
    parameter bit BIG = 1'b1
) (
    input  logic [DW-1:0]            lanes_in,
    input  logic [$clog2(DW/8)-1:0]  lane_sel,
    input  logic                     pick_byte,
    output logic [DW-1:0]            value
);
    localparam int NB     = DW / 8;
    localparam int LANE_W = $clog2(NB);

    logic [DW-1:0] word_val;
    logic [7:0]    byte_val;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        if (BIG) begin : g_big
            assign word_val[DW-1-8*k -: 8] = lanes_in[8*k +: 8];
        end else begin : g_little
            assign word_val[8*k +: 8] = lanes_in[8*k +: 8];
        end
    end

    // Select the addressed lane for a byte load.
    always_comb begin
        byte_val = 8'h00;
        for (int k = 0; k < NB; k++) begin
            if (lane_sel == LANE_W'(k)) byte_val = lanes_in[8*k +: 8];
        end
    end

    // Choose between the full word and the sign-extended byte.
    always_comb begin
        value = pick_byte ? {{(DW-8){byte_val[7]}}, byte_val} : word_val;
    end
endmodule

// File: rtl/lsu_core.sv
// Load store unit top: decodes the request, refuses misaligned word
// accesses, drives a synchronous memory and returns a response one
// cycle later. Assumes memory read data arrives one clock after
// mem_rd_en and that mem_wr_en writes all lanes.
module lsu_core
    import lsu_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int OFF_W      = 16,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    base_addr,
    input  logic [OFF_W-1:0] offset,
    input  logic [DW-1:0]    store_data,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             resp_valid,
    output logic [DW-1:0]    resp_data,
    output logic             fault
);
    localparam int LANE_W = $clog2(DW/8);

    lsu_op_e           op;
    logic              accept, word_op, fault_now, unaligned;
    logic [LANE_W-1:0] lane, lane_q;
    logic              rsp_valid_q, fault_q, load_q, byte_q;
    logic [DW-1:0]     unpacked;

    lsu_agen #(.AW(AW), .OFF_W(OFF_W), .DW(DW)) u_agen (
        .base      (base_addr),
        .disp      (offset),
        .line_addr (mem_addr),
        .lane      (lane),
        .unaligned (unaligned)
    );

    lsu_store_pack #(.DW(DW), .BIG(BIG_ENDIAN)) u_pack (
        .word_in   (store_data),
        .lanes_out (mem_wdata)
    );

    lsu_load_unpack #(.DW(DW), .BIG(BIG_ENDIAN)) u_unpack (
        .lanes_in  (mem_rdata),
        .lane_sel  (lane_q),
        .pick_byte (byte_q),
        .value     (unpacked)
    );

    // Decode the request and gate memory strobes on alignment.
    always_comb begin
        op        = lsu_op_e'(req_op);
        accept    = req_valid && (op != OP_NOP);
        word_op   = (op == OP_LDW) || (op == OP_STW);
        fault_now = accept && word_op && unaligned;
        mem_rd_en = accept && !fault_now && (op != OP_STW);
        mem_wr_en = accept && !fault_now && (op == OP_STW);
    end

    // Register the response context for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            fault_q     <= 1'b0;
            load_q      <= 1'b0;
            byte_q      <= 1'b0;
            lane_q      <= '0;
        end else begin
            rsp_valid_q <= accept;
            fault_q     <= fault_now;
            load_q      <= mem_rd_en;
            byte_q      <= mem_rd_en && (op == OP_LDB);
            lane_q      <= lane;
        end
    end

    // Drive the response; only a completed load returns data.
    always_comb begin
        resp_valid = rsp_valid_q;
        fault      = fault_q;
        resp_data  = load_q ? unpacked : '0;
    end

    // R8: every accepted request is answered in the next cycle.
    a_r8_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b11) |=> resp_valid);

    // R2: idle or invalid requests produce no response.
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op != 2'b11) |=> !resp_valid);

    // R3: a misaligned word request never reaches memory.
    a_r3_no_mem_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 2'b00 || req_op == 2'b01)
         && ((base_addr[1:0] + offset[1:0]) != 2'b00))
        |-> (!mem_wr_en && !mem_rd_en));

    // R3: a faulting response carries zero data.
    a_r3_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (resp_valid && resp_data == '0));

    // R7: writes are whole aligned words and never overlap a read.
    a_r7_store_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr[1:0] == 2'b00 && !mem_rd_en));

    // R6: a byte load result is sign-extended from bit 7.
    a_r6_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_q && byte_q) |-> (resp_data[DW-1:8] == {(DW-8){resp_data[7]}}));
endmodule

// File: tb/tb_lsu_core.sv
// Bench: two units (big- and little-endian) share one request stream,
// each with its own 256-byte synchronous memory and its own reference image.
module tb_lsu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;

    logic [31:0] addr_b, addr_l, wd_b, wd_l, rd_b, rd_l, rsp_b, rsp_l;
    logic        re_b, re_l, we_b, we_l, rv_b, rv_l, ft_b, ft_l;

    logic [7:0] mem_b [256];
    logic [7:0] mem_l [256];
    logic [7:0] ref_b [256];
    logic [7:0] ref_l [256];

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lsu_core #(.BIG_ENDIAN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base_addr(base_addr), .offset(offset), .store_data(store_data),
        .mem_addr(addr_b), .mem_rd_en(re_b), .mem_wr_en(we_b), .mem_wdata(wd_b),
        .mem_rdata(rd_b), .resp_valid(rv_b), .resp_data(rsp_b), .fault(ft_b));

    lsu_core #(.BIG_ENDIAN(1'b0)) dut_le (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base_addr(base_addr), .offset(offset), .store_data(store_data),
        .mem_addr(addr_l), .mem_rd_en(re_l), .mem_wr_en(we_l), .mem_wdata(wd_l),
        .mem_rdata(rd_l), .resp_valid(rv_l), .resp_data(rsp_l), .fault(ft_l));

    // Synchronous memories: lane k holds the byte at address + k.
    always @(posedge clk) begin
        if (re_b) rd_b <= {mem_b[addr_b[7:0]+8'd3], mem_b[addr_b[7:0]+8'd2],
                           mem_b[addr_b[7:0]+8'd1], mem_b[addr_b[7:0]]};
        if (we_b) for (int k = 0; k < 4; k++) mem_b[addr_b[7:0]+8'(k)] <= wd_b[8*k +: 8];
        if (re_l) rd_l <= {mem_l[addr_l[7:0]+8'd3], mem_l[addr_l[7:0]+8'd2],
                           mem_l[addr_l[7:0]+8'd1], mem_l[addr_l[7:0]]};
        if (we_l) for (int k = 0; k < 4; k++) mem_l[addr_l[7:0]+8'(k)] <= wd_l[8*k +: 8];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sext8(input logic [7:0] b);
        return {{24{b[7]}}, b};
    endfunction

    // Issue one request at a falling edge, check strobes, then check the response.
    task automatic issue(input logic [1:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] sd);
        logic [31:0] ea, wa, eb, el;
        logic        acc, bad, ev, ef;
        ea  = base + {{16{off[15]}}, off};
        wa  = {ea[31:2], 2'b00};
        acc = (op != 2'b11);
        bad = (op == 2'b00 || op == 2'b01) && (ea[1:0] != 2'b00);
        ev = acc; ef = bad; eb = '0; el = '0;
        req_valid = 1'b1; req_op = op; base_addr = base; offset = off; store_data = sd;
        #1;
        if (!acc || bad) begin
            chk(acc ? "R3 strobes off (be)" : "R2 strobes off (be)", {30'd0, re_b, we_b}, 32'd0);
            chk(acc ? "R3 strobes off (le)" : "R2 strobes off (le)", {30'd0, re_l, we_l}, 32'd0);
        end else begin
            chk("R1 address (be)", addr_b, wa);
            chk("R1 address (le)", addr_l, wa);
            if (op == 2'b01) begin
                chk("R7 lanes (be)", wd_b, {sd[7:0], sd[15:8], sd[23:16], sd[31:24]});
                chk("R7 lanes (le)", wd_l, sd);
                chk("R7 write strobe", {30'd0, we_b, we_l}, 32'd3);
                for (int k = 0; k < 4; k++) begin
                    ref_b[wa[7:0]+8'(k)] = sd[31-8*k -: 8];
                    ref_l[wa[7:0]+8'(k)] = sd[8*k +: 8];
                end
            end else if (op == 2'b00) begin
                eb = {ref_b[wa[7:0]], ref_b[wa[7:0]+8'd1], ref_b[wa[7:0]+8'd2], ref_b[wa[7:0]+8'd3]};
                el = {ref_l[wa[7:0]+8'd3], ref_l[wa[7:0]+8'd2], ref_l[wa[7:0]+8'd1], ref_l[wa[7:0]]};
            end else begin
                eb = sext8(ref_b[ea[7:0]]);
                el = sext8(ref_l[ea[7:0]]);
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b11;
        chk(acc ? "R8 resp_valid (be)" : "R2 no response (be)", {31'd0, rv_b}, {31'd0, ev});
        chk(acc ? "R8 resp_valid (le)" : "R2 no response (le)", {31'd0, rv_l}, {31'd0, ev});
        chk("R3 fault (be)", {31'd0, ft_b}, {31'd0, ef});
        chk("R3 fault (le)", {31'd0, ft_l}, {31'd0, ef});
        if (ev) begin
            chk(op == 2'b00 ? "R4 word load" : (op == 2'b10 ? "R6 byte load (be)" : "R8 store/fault data (be)"), rsp_b, eb);
            chk(op == 2'b00 ? "R5 word load" : (op == 2'b10 ? "R6 byte load (le)" : "R8 store/fault data (le)"), rsp_l, el);
        end
    endtask

    initial begin
        logic [31:0] rb, ro;
        for (int i = 0; i < 256; i++) begin
            mem_b[i] = 8'(i * 37 + 11); mem_l[i] = mem_b[i];
            ref_b[i] = mem_b[i];        ref_l[i] = mem_b[i];
        end
        mem_b[0] = 8'd2;  mem_b[1] = 8'd3;  mem_b[2] = 8'd10; mem_b[3] = 8'd1; mem_b[5] = 8'hF0;
        for (int i = 0; i < 6; i++) begin mem_l[i] = mem_b[i]; ref_b[i] = mem_b[i]; ref_l[i] = mem_b[i]; end
        void'($urandom(32'd5713));

        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 resp_valid", {31'd0, rv_b | rv_l}, 32'd0);
        chk("R9 fault", {31'd0, ft_b | ft_l}, 32'd0);
        chk("R9 resp_data", rsp_b | rsp_l, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5: the same four bytes in both orderings
        issue(2'b00, 32'd0, 16'd0, 32'd0);
        chk("R4 literal 33753601", rsp_b, 32'd33753601);
        chk("R5 literal 17433346", rsp_l, 32'd17433346);
        // R1: positive and negative displacements, wrap past zero
        issue(2'b00, 32'd0, 16'd20, 32'd0);
        issue(2'b00, 32'd100, 16'hFFFC, 32'd0);
        issue(2'b10, 32'd2, 16'hFFFF, 32'd0);
        chk("R6 literal byte 3", rsp_b, 32'd3);
        issue(2'b00, 32'hFFFF_FFF8, 16'd12, 32'd0);
        // R6: negative byte, unaligned addresses
        issue(2'b10, 32'd5, 16'd0, 32'd0);
        chk("R6 literal sign", rsp_l, 32'hFFFF_FFF0);
        issue(2'b10, 32'd3, 16'd0, 32'd0);
        // R3: misaligned word load and store; store must leave memory untouched
        issue(2'b00, 32'd1, 16'd1, 32'd0);
        issue(2'b01, 32'd6, 16'd0, 32'hDEAD_BEEF);
        issue(2'b00, 32'd4, 16'd0, 32'd0);
        // R7: aligned store then byte reads of its lowest address
        issue(2'b01, 32'd8, 16'd0, 32'hA1B2_C3D4);
        issue(2'b10, 32'd8, 16'd0, 32'd0);
        chk("R7 lowest byte (be)", rsp_b, 32'hFFFF_FFA1);
        chk("R7 lowest byte (le)", rsp_l, 32'hFFFF_FFD4);
        issue(2'b00, 32'd4, 16'd4, 32'd0);
        chk("R7 read back (be)", rsp_b, 32'hA1B2_C3D4);
        chk("R7 read back (le)", rsp_l, 32'hA1B2_C3D4);
        // R2: idle op with valid high, then a silent cycle
        issue(2'b11, 32'd0, 16'd0, 32'd0);
        @(negedge clk);
        chk("R2 quiet cycle", {30'd0, rv_b, rv_l}, 32'd0);

        // Random mix, half forced onto word boundaries
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] op;
            op = 2'($urandom % 4);
            rb = $urandom;
            ro = $urandom;
            if ($urandom % 2 == 0) rb[1:0] = 2'(-ro[1:0]);
            issue(op, rb, ro[15:0], $urandom);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule